// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block recovers asynchronous serial words from one receive line. A prescaler turns the module clock into a sample tick. Between 4 and 16 ticks make one bit period, and the ratio is chosen at run time. The raw line first crosses a two-flop synchronizer. It then passes a glitch filter of programmable depth. Each bit is decided by a majority vote over three ticks centred on a programmable sample point.

A falling edge on the line starts a frame. The start bit must still read low at the vote, otherwise the receiver drops back to idle. The block then collects 7 to 16 data bits, least or most significant bit first. It checks an optional even or odd parity bit and one or two stop bits. Each finished word is offered on a valid/ready output with its frame and parity error flags. A one-cycle end-of-frame pulse marks each completed frame. If the previous word is still waiting there, the new word is dropped and an overrun pulse is raised.

Top module: `srx_top`

## Requirements
- R1: A sample tick occurs once every `cfg_div`+1 clocks, and one bit lasts `cfg_osr` ticks; `cfg_osr` values below 4 act as 4 and above 16 act as 16.
- R2: The value of each bit is voted from ticks `cfg_spt`-1, `cfg_spt` and `cfg_spt`+1 of that bit (tick 0 is the first tick that sees the start edge); `cfg_spt` is limited to the range 1 to `cfg_osr`-2.
- R3: The filtered line takes a new level only after the synchronized input has held that level for `cfg_glitch`+1 consecutive clocks, so shorter pulses are removed.
- R4: A single corrupted tick among the three voting ticks does not change the decided bit value.
- R5: A start that reads high at its vote is rejected: the receiver returns to idle, and no word, end-of-frame pulse or error is produced.
- R6: The word length is `cfg_len` bits, with values below 7 acting as 7 and above 16 acting as 16; bits of `out_data` above the word length are zero.
- R7: With `cfg_msb_first`=0 the first data bit on the line lands in `out_data[0]`; with 1 it lands in `out_data[len-1]`.
- R8: When `cfg_par_en`=1 a parity bit follows the data; the expected value is the XOR of the data bits, inverted when `cfg_par_odd`=1. A mismatch sets `err_parity` with the word.
- R9: `cfg_two_stop` selects one or two stop bits; any stop bit voted low sets `err_frame`, and the word is still delivered.
- R10: After reset `out_valid`, `out_eof` and `err_overrun` are low. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R11: If a word completes while `out_valid` is high and `out_ready` is low, `err_overrun` pulses for one cycle, the new word is discarded and the held word is kept.
- R12: `out_eof` pulses for one clock at the vote of the last stop bit of every completed frame, including one that is discarded by overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| cfg_div | input | DIV_W | Sample tick prescaler, tick every value+1 clocks |
| cfg_osr | input | 5 | Ticks per bit, 4 to 16 |
| cfg_spt | input | 5 | Centre tick of the three-tick vote |
| cfg_glitch | input | GLT_W | Glitch filter depth in clocks |
| cfg_len | input | 5 | Data bits per word, 7 to 16 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when high, even when low |
| cfg_two_stop | input | 1 | Two stop bits when high |
| cfg_msb_first | input | 1 | Most significant data bit first when high |
| out_data | output | DATA_W | Received word |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_eof | output | 1 | One-cycle end-of-frame pulse |
| err_frame | output | 1 | Stop bit read low, held with the word |
| err_parity | output | 1 | Parity mismatch, held with the word |
| err_overrun | output | 1 | One-cycle pulse, new word dropped |

## Verification
A table of frames sweeps the ratio, the sample point (including the last legal tick, where the vote and the bit boundary coincide), the prescaler, the word length, the bit order, the parity sense and the stop count. Out-of-range settings show that the clamps match the stated limits, and words with bad parity or a low stop bit show that the errors are told apart. Directed frames follow. One-clock inversions at the sample point separate a majority vote from a single sample. Two-clock pulses with a deep filter show the glitch filter at work. A short low pulse exercises false-start rejection. Two back-to-back frames with the output stalled provoke an overrun and show the held word surviving.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int CFG_W = 5;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP1 = 3'd4,
    S_STOP2 = 3'd5
  } rx_state_t;

  // ticks per bit, held to 4..16
  function automatic logic [CFG_W-1:0] fit_osr(input logic [CFG_W-1:0] v);
    if (v < 5'd4)  return 5'd4;
    if (v > 5'd16) return 5'd16;
    return v;
  endfunction

  // vote centre, held to 1..osr-2 so all three ticks fit in the bit
  function automatic logic [CFG_W-1:0] fit_spt(input logic [CFG_W-1:0] v,
                                               input logic [CFG_W-1:0] osr);
    logic [CFG_W-1:0] lim;
    lim = osr - 5'd2;
    if (v < 5'd1) return 5'd1;
    if (v > lim)  return lim;
    return v;
  endfunction

  // word length, held to 7..16
  function automatic logic [CFG_W-1:0] fit_len(input logic [CFG_W-1:0] v);
    if (v < 5'd7)  return 5'd7;
    if (v > 5'd16) return 5'd16;
    return v;
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // output bit position of the k-th received data bit
  function automatic logic [CFG_W-1:0] bit_slot(input logic [CFG_W-1:0] k,
                                                input logic [CFG_W-1:0] len,
                                                input logic msb);
    return msb ? (len - 5'd1 - k) : k;
  endfunction

endpackage

// File: rtl/srx_tick.sv
module srx_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R1: after a tick the counter restarts, so a second tick follows only for a divider of zero
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || div == '0));

endmodule

// File: rtl/srx_filt.sv
module srx_filt #(
  parameter int GLT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [GLT_W-1:0] depth,
  output logic             line_o
);

  logic [1:0]       sync_q;
  logic             din_s;
  logic [GLT_W-1:0] run_cnt;

  assign din_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      line_o  <= 1'b1;
      run_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      if (din_s == line_o) begin
        run_cnt <= '0;
      end else if (run_cnt >= depth) begin
        line_o  <= din_s;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R3: the filtered line only ever moves toward the synchronized input
  p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_o) |-> line_o == $past(din_s));

endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic [CFG_W-1:0]  cfg_osr,
  input  logic [CFG_W-1:0]  cfg_spt,
  input  logic [CFG_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_msb_first,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_eof,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);

  localparam int IDX_W = $clog2(DATA_W);

  rx_state_t         state;
  logic [CFG_W-1:0]  sub, bitk;
  logic [DATA_W-1:0] shreg;
  logic              smp_lo, smp_mid;
  logic              par_acc, ferr_acc, perr_acc;

  logic [CFG_W-1:0]  osr_c, spt_c, len_c, slot_full;
  logic [IDX_W-1:0]  sidx;
  logic              at_lo, at_mid, at_vote, at_end, vote;
  logic              false_start, word_done, frame_bad;

  assign osr_c     = fit_osr(cfg_osr);
  assign spt_c     = fit_spt(cfg_spt, osr_c);
  assign len_c     = fit_len(cfg_len);
  assign slot_full = bit_slot(bitk, len_c, cfg_msb_first);
  assign sidx      = slot_full[IDX_W-1:0];

  assign at_lo   = tick && (sub == spt_c - 5'd1);
  assign at_mid  = tick && (sub == spt_c);
  assign at_vote = tick && (sub == spt_c + 5'd1) && (state != S_IDLE);
  assign at_end  = tick && (sub == osr_c - 5'd1) && (state != S_IDLE);
  assign vote    = maj3(smp_lo, smp_mid, line);

  assign false_start = at_vote && (state == S_START) && vote;
  assign word_done   = at_vote && (((state == S_STOP1) && !cfg_two_stop) ||
                                   (state == S_STOP2));
  assign frame_bad   = ferr_acc | ~vote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      sub         <= '0;
      bitk        <= '0;
      shreg       <= '0;
      smp_lo      <= 1'b1;
      smp_mid     <= 1'b1;
      par_acc     <= 1'b0;
      ferr_acc    <= 1'b0;
      perr_acc    <= 1'b0;
      out_data    <= '0;
      out_valid   <= 1'b0;
      out_eof     <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      out_eof     <= 1'b0;
      err_overrun <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;

      if (tick) begin
        if (at_lo)  smp_lo  <= line;
        if (at_mid) smp_mid <= line;

        if (state == S_IDLE) begin
          smp_lo <= line;               // tick 0 of a start bit
          if (!line) begin
            state    <= S_START;
            sub      <= 5'd1;
            bitk     <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            ferr_acc <= 1'b0;
            perr_acc <= 1'b0;
          end
        end else begin
          sub <= at_end ? '0 : sub + 5'd1;

          if (at_vote) begin
            case (state)
              S_DATA: begin
                shreg[sidx] <= vote;
                par_acc     <= par_acc ^ vote;
              end
              S_PAR:            perr_acc <= (vote != (par_acc ^ cfg_par_odd));
              S_STOP1, S_STOP2: if (!vote) ferr_acc <= 1'b1;
              default: ;
            endcase
          end

          if (at_end) begin
            case (state)
              S_START: begin
                state <= S_DATA;
                bitk  <= '0;
              end
              S_DATA: begin
                if (bitk == len_c - 5'd1) state <= cfg_par_en ? S_PAR : S_STOP1;
                else                      bitk  <= bitk + 5'd1;
              end
              S_PAR:   state <= S_STOP1;
              S_STOP1: state <= S_STOP2;
              default: state <= S_IDLE;
            endcase
          end

          if (false_start || word_done) state <= S_IDLE;

          if (word_done) begin
            out_eof <= 1'b1;
            if (out_valid && !out_ready) begin
              err_overrun <= 1'b1;
            end else begin
              out_data   <= shreg;
              err_frame  <= frame_bad;
              err_parity <= perr_acc;
              out_valid  <= 1'b1;
            end
          end
        end
      end
    end
  end

  // R10: a stalled word is neither withdrawn nor altered
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R11: an overrun leaves the earlier word in place
  p_overrun_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> (out_eof && out_valid && $stable(out_data)));

  // R12: an end-of-frame pulse comes only out of a stop bit
  p_eof_from_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> (state == S_IDLE &&
                 ($past(state) == S_STOP1 || $past(state) == S_STOP2)));

  // R5: a rejected start produces no frame
  p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> (state == S_IDLE && !out_eof));

endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int GLT_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [4:0]        cfg_osr,
  input  logic [4:0]        cfg_spt,
  input  logic [GLT_W-1:0]  cfg_glitch,
  input  logic [4:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_msb_first,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_eof,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);

  logic sample_tick;
  logic line_f;

  srx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (cfg_div),
    .tick (sample_tick)
  );

  srx_filt #(.GLT_W(GLT_W)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .rx_i  (rx_i),
    .depth (cfg_glitch),
    .line_o(line_f)
  );

  srx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (sample_tick),
    .line         (line_f),
    .cfg_osr      (cfg_osr),
    .cfg_spt      (cfg_spt),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .cfg_two_stop (cfg_two_stop),
    .cfg_msb_first(cfg_msb_first),
    .out_data     (out_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_eof      (out_eof),
    .err_frame    (err_frame),
    .err_parity   (err_parity),
    .err_overrun  (err_overrun)
  );

endmodule

// File: tb/srx_top_tb.sv
module srx_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_i = 1'b1;
  logic [11:0] cfg_div = '0;
  logic [4:0]  cfg_osr = 5'd16;
  logic [4:0]  cfg_spt = 5'd8;
  logic [3:0]  cfg_glitch = '0;
  logic [4:0]  cfg_len = 5'd8;
  logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0, cfg_msb_first = 1'b0;
  logic [15:0] out_data;
  logic        out_valid, out_ready = 1'b1, out_eof, err_frame, err_parity, err_overrun;

  always #4 clk = ~clk;

  srx_top u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .cfg_div(cfg_div), .cfg_osr(cfg_osr),
    .cfg_spt(cfg_spt), .cfg_glitch(cfg_glitch), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_msb_first(cfg_msb_first), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_eof(out_eof), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );

  typedef struct packed {
    logic [4:0]  osr;
    logic [4:0]  spt;
    logic [3:0]  dv;
    logic [4:0]  len;
    logic        pe, po, ts, msb;
    logic [3:0]  glt;
    logic [15:0] data;
    logic        bpar, bstop;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'd16, 5'd8,  4'd0, 5'd8,  1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 16'h00A5, 1'b0, 1'b0}, // R1 R2
    '{5'd4,  5'd1,  4'd2, 5'd8,  1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 16'h003C, 1'b0, 1'b0}, // R8 even
    '{5'd8,  5'd6,  4'd1, 5'd9,  1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 16'h01B3, 1'b0, 1'b0}, // R8 odd, R9
    '{5'd16, 5'd14, 4'd0, 5'd16, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 16'hC35A, 1'b0, 1'b0}, // R7 R6 R2
    '{5'd5,  5'd2,  4'd3, 5'd7,  1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h00FF, 1'b0, 1'b0}, // R6 mask
    '{5'd12, 5'd5,  4'd0, 5'd8,  1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 16'h0096, 1'b1, 1'b0}, // R8 error
    '{5'd16, 5'd8,  4'd0, 5'd8,  1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 16'h0042, 1'b0, 1'b1}, // R9 error
    '{5'd2,  5'd0,  4'd1, 5'd20, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'hBEEF, 1'b0, 1'b0}  // R1 R6 clamps
  };

  int checks = 0, errors = 0;
  int n_eof = 0, n_ovr = 0;
  logic        got = 1'b0;
  logic [15:0] got_data = '0;
  logic        got_fe = 1'b0, got_pe = 1'b0;
  logic        done = 1'b0;

  always @(negedge clk) begin
    if (out_eof)     n_eof = n_eof + 1;
    if (err_overrun) n_ovr = n_ovr + 1;
    if (out_valid && out_ready) begin
      got      = 1'b1;
      got_data = out_data;
      got_fe   = err_frame;
      got_pe   = err_parity;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lim(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic hold(input logic b, input int n);
    rx_i = b;
    repeat (n) @(negedge clk);
  endtask

  // mode 0 clean, 1 two-clock inversion early in each data bit, 2 one-clock inversion at clock 8
  task automatic send(input int osr, input int dv, input int len, input logic pe,
                      input logic po, input logic ts, input logic msb, input logic [15:0] d,
                      input logic bpar, input logic bstop, input int mode);
    int bp;
    logic [31:0] mask;
    bp   = (dv + 1) * osr;
    mask = (32'h1 << len) - 1;
    hold(1'b0, bp);
    for (int k = 0; k < len; k++) begin
      logic b;
      b = msb ? d[len-1-k] : d[k];
      if (mode == 1) begin
        hold(b, 1); hold(!b, 2); hold(b, bp - 3);
      end else if (mode == 2) begin
        hold(b, 8); hold(!b, 1); hold(b, bp - 9);
      end else begin
        hold(b, bp);
      end
    end
    if (pe) hold((^({16'h0, d} & mask)) ^ po ^ bpar, bp);
    hold(!bstop, bp);
    if (ts) hold(1'b1, bp);
    hold(1'b1, 2 * bp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 valid after reset", {31'b0, out_valid}, 32'd0);
    chk("R10 eof after reset", {31'b0, out_eof}, 32'd0);
    chk("R11 overrun after reset", {31'b0, err_overrun}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int osr_e, len_e;
      logic [31:0] exp_d;
      osr_e = lim(int'(VECS[i].osr), 4, 16);
      len_e = lim(int'(VECS[i].len), 7, 16);
      exp_d = {16'h0, VECS[i].data} & ((32'h1 << len_e) - 1);
      cfg_osr = VECS[i].osr; cfg_spt = VECS[i].spt; cfg_div = {8'h0, VECS[i].dv};
      cfg_len = VECS[i].len; cfg_par_en = VECS[i].pe; cfg_par_odd = VECS[i].po;
      cfg_two_stop = VECS[i].ts; cfg_msb_first = VECS[i].msb; cfg_glitch = VECS[i].glt;
      got = 1'b0;
      repeat (4) @(negedge clk);
      send(osr_e, int'(VECS[i].dv), len_e, VECS[i].pe, VECS[i].po, VECS[i].ts,
           VECS[i].msb, VECS[i].data, VECS[i].bpar, VECS[i].bstop, 0);
      chk($sformatf("R1 R2 vec%0d word seen", i), {31'b0, got}, 32'd1);
      chk($sformatf("R6 R7 vec%0d data", i), {16'h0, got_data}, exp_d);
      chk($sformatf("R8 vec%0d parity flag", i), {31'b0, got_pe}, {31'b0, VECS[i].pe & VECS[i].bpar});
      chk($sformatf("R9 vec%0d frame flag", i), {31'b0, got_fe}, {31'b0, VECS[i].bstop});
    end

    // R4: one-clock inversions at the sample point are outvoted
    cfg_osr = 5'd16; cfg_spt = 5'd8; cfg_div = '0; cfg_len = 5'd8; cfg_par_en = 1'b0;
    cfg_two_stop = 1'b0; cfg_msb_first = 1'b0; cfg_glitch = 4'd0; got = 1'b0;
    send(16, 0, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0055, 1'b0, 1'b0, 2);
    chk("R4 median vote data", {16'h0, got_data}, 32'h55);

    // R3: two-clock pulses removed by a depth-3 filter at 4 ticks per bit
    cfg_osr = 5'd4; cfg_spt = 5'd1; cfg_glitch = 4'd3; got = 1'b0;
    send(4, 0, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1);
    chk("R3 glitch filter data", {16'h0, got_data}, 32'h0);
    chk("R3 glitch filter word seen", {31'b0, got}, 32'd1);

    // R5: short low pulse is a rejected start
    begin
      int eof_before;
      cfg_osr = 5'd16; cfg_spt = 5'd8; cfg_glitch = 4'd0; got = 1'b0;
      eof_before = n_eof;
      hold(1'b0, 4); hold(1'b1, 48);
      chk("R5 no eof after false start", n_eof, eof_before);
      chk("R5 no word after false start", {31'b0, got}, 32'd0);
      send(16, 0, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16'h003A, 1'b0, 1'b0, 0);
      chk("R5 frame after rejected start", {16'h0, got_data}, 32'h3A);
    end

    // R11 R10: stalled output, second word dropped
    begin
      int ovr_before;
      ovr_before = n_ovr;
      out_ready = 1'b0;
      send(16, 0, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0011, 1'b0, 1'b0, 0);
      send(16, 0, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0022, 1'b0, 1'b0, 0);
      chk("R11 one overrun pulse", n_ovr - ovr_before, 32'd1);
      chk("R11 held word kept", {16'h0, out_data}, 32'h11);
      repeat (20) @(negedge clk);
      chk("R10 valid held while stalled", {31'b0, out_valid}, 32'd1);
      chk("R10 data held while stalled", {16'h0, out_data}, 32'h11);
      out_ready = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 valid drops after accept", {31'b0, out_valid}, 32'd0);
    end

    // R12: one end-of-frame per completed frame (8 table + 5 directed)
    chk("R12 eof count", n_eof, 32'd13);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule